// File: doc/BRIEF.md
# Programmable Bidirectional Parallel Port

This block is an 8-bit parallel port. A direction register sets each data line separately as an input or an output. A small synchronous register interface lets the processor write output data, set the directions, pick an operating mode and read status. The port has two kinds of mode. In the plain modes the data register drives the output lines directly and the input lines are sampled every cycle. In the two handshake modes a Ready/Accept exchange with the device paces each transfer. One handshake mode sends data and the other receives it.

The pads are modelled as three separate vectors: output value, output enable and sampled input. The device's Accept strobe is edge-detected, so one high level on it counts as exactly one event. An interrupt line asks for service when a handshake transfer has finished, if the processor has enabled interrupts. The handshake sequencing is a five-state machine:

- **ST_IDLE**: no transfer is in progress.
- **ST_OUT_WAIT**: Ready is high and the output byte is being offered.
- **ST_IN_WAIT**: waiting for the device to strobe in a byte.
- **ST_IN_FULL**: a captured byte is waiting for the processor.
- **ST_IN_ACK**: a one-cycle Ready pulse back to the device.

The transitions are:

- **T_SEND**: ST_IDLE to ST_OUT_WAIT on a data write in send mode.
- **T_TAKEN**: ST_OUT_WAIT to ST_IDLE on an Accept edge.
- **T_ARM**: ST_IDLE to ST_IN_WAIT when the mode is receive.
- **T_CAPTURE**: ST_IN_WAIT to ST_IN_FULL on an Accept edge.
- **T_DRAIN**: ST_IN_FULL to ST_IN_ACK on a data read.
- **T_REARM**: ST_IN_ACK to ST_IN_WAIT.
- **T_RESTART**: from any state on a control write. It goes to ST_IN_WAIT if the new mode is receive, and to ST_IDLE otherwise.

Top module: `pport_top`

## Requirements
- R1: After reset the direction register is 0 (pad_oe = 0), the mode is plain, hs_ready and irq are low, and the control/status register reads 0.
- R2: A write to offset 1 loads the direction register; bit value 1 makes that line an output. pad_oe shows the new value in the cycle after the write.
- R3: In plain mode, pad_out shows the data register (offset 0). A read of offset 0 returns the written value on output lines and, on input lines, pad_in as sampled one clock earlier.
- R4: The control/status register is at offset 2. Bits [1:0] are the mode: 00 plain, 01 send handshake, 10 receive handshake, 11 plain. Bit 2 is the interrupt enable. Bit 3 (done) and bit 4 (available) are read-only flags. In both plain modes hs_ready stays low and Accept changes no flag.
- R5: In send mode, a data write raises hs_ready in the next cycle and pad_out holds the byte. A rising edge on hs_accept drops hs_ready and sets done in the next cycle. A data write clears done.
- R6: In receive mode, a rising edge on hs_accept captures pad_in and sets the available flag. Later changes on pad_in do not alter the value read from offset 0.
- R7: In receive mode, a read of offset 0 while a byte is held clears the available flag and raises hs_ready for exactly one cycle. An Accept edge while a byte is held is ignored and does not overwrite the held byte.
- R8: irq is high exactly when the interrupt enable is 1 and done or available is 1. With the enable at 0, irq stays low.
- R9: Any write to the control register clears both flags and ends an open handshake, so hs_ready goes low.
- R10: Accept is edge-detected. Holding hs_accept high counts as one event only, so a new send started while it stays high keeps hs_ready asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 data, 1 direction, 2 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Sampled line values |
| pad_out | output | 8 | Line drive values |
| pad_oe | output | 8 | Per-line output enable |
| hs_ready | output | 1 | Handshake Ready to the device |
| hs_accept | input | 1 | Handshake Accept from the device |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check these properties:

- Ready never rises in a plain mode.
- The receive-side Ready pulse lasts one cycle.
- An Accept edge during a send drops Ready.
- The output byte stays stable while it is offered.
- The interrupt is masked by its enable.
- The enables follow a direction write.

Only the bench scenarios can show the values involved. These are the captured byte versus later pin changes, the mixed read-back of input and output lines, the flag encodings in the status word, and that a second Accept edge is ignored while a byte is still held.

// File: rtl/pport_pkg.sv
package pport_pkg;
    typedef enum logic [1:0] {
        MD_PLAIN     = 2'b00,
        MD_HS_OUT    = 2'b01,
        MD_HS_IN     = 2'b10,
        MD_PLAIN_ALT = 2'b11
    } port_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_OUT_WAIT = 3'd1,
        ST_IN_WAIT  = 3'd2,
        ST_IN_FULL  = 3'd3,
        ST_IN_ACK   = 3'd4
    } hs_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIR  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int BIT_IEN   = 2;
    localparam int BIT_DONE  = 3;
    localparam int BIT_AVAIL = 4;
endpackage

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] rd_value,
    input  logic             done,
    input  logic             avail,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] data_out,
    output logic [WIDTH-1:0] ddr,
    output port_mode_t       mode,
    output logic             ien,
    output logic             wr_data_stb,
    output logic             rd_data_stb,
    output logic             ctrl_wr_stb,
    output port_mode_t       new_mode
);
    logic wr_dir_stb;

    always_comb begin
        wr_data_stb = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
        wr_dir_stb  = bus_sel && bus_wr && (bus_addr == ADDR_DIR);
        ctrl_wr_stb = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
        rd_data_stb = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
        new_mode    = port_mode_t'(bus_wdata[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            ddr      <= '0;
            mode     <= MD_PLAIN;
            ien      <= 1'b0;
        end else begin
            if (wr_data_stb) data_out <= bus_wdata;
            if (wr_dir_stb)  ddr      <= bus_wdata;
            if (ctrl_wr_stb) begin
                mode <= new_mode;
                ien  <= bus_wdata[BIT_IEN];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = rd_value;
            ADDR_DIR:  bus_rdata = ddr;
            ADDR_CTRL: begin
                bus_rdata[1:0]       = mode;
                bus_rdata[BIT_IEN]   = ien;
                bus_rdata[BIT_DONE]  = done;
                bus_rdata[BIT_AVAIL] = avail;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_pad.sv
module pport_pad #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_out,
    input  logic [WIDTH-1:0] ddr,
    input  logic [WIDTH-1:0] pad_in,
    input  logic             latch_en,
    input  logic             use_hold,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] rd_value
);
    logic [WIDTH-1:0] in_samp;
    logic [WIDTH-1:0] in_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_samp <= '0;
            in_hold <= '0;
        end else begin
            in_samp <= pad_in;
            if (latch_en) in_hold <= pad_in;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_comb begin
            pad_out[i] = data_out[i];
            pad_oe[i]  = ddr[i];
            if (ddr[i])        rd_value[i] = data_out[i];
            else if (use_hold) rd_value[i] = in_hold[i];
            else               rd_value[i] = in_samp[i];
        end
    end
endmodule

// File: rtl/pport_hs_fsm.sv
module pport_hs_fsm
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  port_mode_t mode,
    input  port_mode_t new_mode,
    input  logic       ctrl_wr,
    input  logic       wr_data,
    input  logic       rd_data,
    input  logic       hs_accept,
    output logic       hs_ready,
    output logic       done,
    output logic       avail,
    output logic       latch_en,
    output logic       accept_rise
);
    hs_state_t state, state_nx;
    logic      acc_q;
    logic      set_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            acc_q <= 1'b0;
        end else begin
            state <= state_nx;
            acc_q <= hs_accept;
        end
    end

    assign accept_rise = hs_accept && !acc_q;

    always_comb begin
        state_nx = state;
        if (ctrl_wr) begin
            state_nx = (new_mode == MD_HS_IN) ? ST_IN_WAIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mode == MD_HS_OUT && wr_data) state_nx = ST_OUT_WAIT;
                    else if (mode == MD_HS_IN)        state_nx = ST_IN_WAIT;
                end
                ST_OUT_WAIT: if (!wr_data && accept_rise) state_nx = ST_IDLE;
                ST_IN_WAIT:  if (accept_rise)             state_nx = ST_IN_FULL;
                ST_IN_FULL:  if (rd_data)                 state_nx = ST_IN_ACK;
                ST_IN_ACK:                                state_nx = ST_IN_WAIT;
                default:                                  state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        hs_ready = (state == ST_OUT_WAIT) || (state == ST_IN_ACK);
        latch_en = (state == ST_IN_WAIT) && accept_rise && !ctrl_wr;
        set_done = (state == ST_OUT_WAIT) && accept_rise && !ctrl_wr && !wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            avail <= 1'b0;
        end else if (ctrl_wr) begin
            done  <= 1'b0;
            avail <= 1'b0;
        end else begin
            if (wr_data)       done <= 1'b0;
            else if (set_done) done <= 1'b1;
            if (latch_en)                          avail <= 1'b1;
            else if (state == ST_IN_FULL && rd_data) avail <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic             hs_ready,
    input  logic             hs_accept,
    output logic             irq
);
    logic [WIDTH-1:0] data_out, ddr, rd_value;
    port_mode_t       mode, new_mode;
    logic             ien, done, avail, latch_en, accept_rise;
    logic             wr_data_stb, rd_data_stb, ctrl_wr_stb;

    pport_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_value(rd_value),
        .done(done), .avail(avail), .bus_rdata(bus_rdata),
        .data_out(data_out), .ddr(ddr), .mode(mode), .ien(ien),
        .wr_data_stb(wr_data_stb), .rd_data_stb(rd_data_stb),
        .ctrl_wr_stb(ctrl_wr_stb), .new_mode(new_mode)
    );

    pport_pad #(.WIDTH(WIDTH)) u_pad (
        .clk(clk), .rst_n(rst_n), .data_out(data_out), .ddr(ddr),
        .pad_in(pad_in), .latch_en(latch_en), .use_hold(mode == MD_HS_IN),
        .pad_out(pad_out), .pad_oe(pad_oe), .rd_value(rd_value)
    );

    pport_hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .new_mode(new_mode),
        .ctrl_wr(ctrl_wr_stb), .wr_data(wr_data_stb), .rd_data(rd_data_stb),
        .hs_accept(hs_accept), .hs_ready(hs_ready), .done(done),
        .avail(avail), .latch_en(latch_en), .accept_rise(accept_rise)
    );

    assign irq = ien && (done || avail);
endmodule

// File: rtl/pport_checker.sv
module pport_checker
    import pport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic             hs_ready,
    input logic             irq,
    input port_mode_t       mode,
    input logic             ien,
    input logic             accept_rise
);
    logic bus_write;
    assign bus_write = bus_sel && bus_wr;

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0) && !hs_ready && !irq); // R1
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_addr == ADDR_DIR) |=> (pad_oe == $past(bus_wdata))); // R2
    AST_NO_READY_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |-> (mode == MD_HS_OUT || mode == MD_HS_IN)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ready && mode == MD_HS_OUT && !bus_write) |=> $stable(pad_out)); // R5
    AST_SEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ready && mode == MD_HS_OUT && accept_rise && !bus_write) |=> !hs_ready); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ready && mode == MD_HS_IN) |=> !hs_ready); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq); // R8
endmodule

bind pport_top pport_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .hs_ready(hs_ready), .irq(irq), .mode(mode),
    .ien(ien), .accept_rise(accept_rise)
);

// File: tb/pport_top_tb.sv
module pport_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic       hs_ready, hs_accept = 1'b0, irq;
    int         n_chk = 0, n_err = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    pport_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .hs_ready(hs_ready), .hs_accept(hs_accept), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic pulse_accept();
        @(negedge clk); hs_accept = 1;
        @(negedge clk); hs_accept = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 ready", {7'd0, hs_ready}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rd(2'd2, v); chk("R1 status", v, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        wr(2'd1, 8'hF0); chk("R2 oe", pad_oe, 8'hF0);
        wr(2'd0, 8'hA5); chk("R3 pad_out", pad_out, 8'hA5);
        @(negedge clk); pad_in = 8'h3C;
        @(negedge clk);
        rd(2'd0, v); chk("R3 mixed read", v, 8'hAC);
        pulse_accept();
        chk("R4 ready plain", {7'd0, hs_ready}, 8'h00);
        rd(2'd2, v); chk("R4 flags plain", v, 8'h00);
        wr(2'd2, 8'h07); wr(2'd0, 8'h11);
        chk("R4 ready mode11", {7'd0, hs_ready}, 8'h00);
        rd(2'd2, v); chk("R4 status mode11", v, 8'h07);
    endtask

    task automatic t_send();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h5A);
        chk("R5 ready up", {7'd0, hs_ready}, 8'h01);
        chk("R5 pad_out", pad_out, 8'h5A);
        repeat (3) @(negedge clk);
        chk("R5 ready held", {7'd0, hs_ready}, 8'h01);
        pulse_accept();
        chk("R5 ready down", {7'd0, hs_ready}, 8'h00);
        rd(2'd2, v); chk("R5 done set", v, 8'h09);
        chk("R8 masked irq", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h05);
        rd(2'd2, v); chk("R9 flags cleared", v, 8'h05);
        wr(2'd0, 8'h66); pulse_accept();
        chk("R8 irq on done", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h77);
        chk("R5 write clears done", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h05);
        chk("R9 ready dropped", {7'd0, hs_ready}, 8'h00);
        wr(2'd0, 8'h12);
        @(negedge clk); hs_accept = 1;
        @(negedge clk);
        chk("R10 first edge", {7'd0, hs_ready}, 8'h00);
        wr(2'd0, 8'h34);
        repeat (2) @(negedge clk);
        chk("R10 held level ignored", {7'd0, hs_ready}, 8'h01);
        hs_accept = 0;
        pulse_accept();
        chk("R10 new edge", {7'd0, hs_ready}, 8'h00);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h06);
        pad_in = 8'h81; pulse_accept();
        rd(2'd2, v); chk("R6 avail set", v, 8'h16);
        chk("R8 irq on avail", {7'd0, irq}, 8'h01);
        pad_in = 8'h7E;
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R6 held byte", v, 8'h81);
        chk("R7 ready pulse", {7'd0, hs_ready}, 8'h01);
        @(negedge clk);
        chk("R7 ready one cycle", {7'd0, hs_ready}, 8'h00);
        rd(2'd2, v); chk("R7 avail cleared", v, 8'h06);
        pad_in = 8'h11; pulse_accept();
        pad_in = 8'h22; pulse_accept();
        rd(2'd0, v); chk("R7 second edge ignored", v, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_send();
        t_receive();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule